// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into a stream of characters. It samples the line on a 16x sampling enable, qualifies each start bit at its centre, and assembles 5 to 8 data bits, least significant bit first. It then checks an optional parity bit and the first stop bit. Each character is stored with its parity, framing and break tags in a 16-entry receive buffer. The host pops characters one at a time and reads the error status separately. The buffer fill level is compared with a selectable threshold to produce a data-available indication.

Word length and parity settings are shared with the transmitter of the same channel, so they come in as static configuration inputs. The error tags of a character are reported only when that character becomes the oldest one in the buffer. They then stay set until the status is read. Overrun is a sticky status of the buffer itself. A dedicated flush input empties the buffer.

Top module: `serial_rx_top`

## Requirements
- R1: A falling edge seen on a sampling tick starts a character. If the line is high again 8 ticks later, at the centre of the start bit, the start is false. The receiver returns to idle and stores nothing.
- R2: Data bits are sampled every 16 ticks after the start-bit centre, least significant bit first. `word_len` 00/01/10/11 selects 5/6/7/8 bits. Unused upper bits of `rx_char` read 0.
- R3: With `par_en`=1, one parity bit follows the data. It is even parity when `par_even`=1 and odd parity when `par_even`=0. When `par_stick`=1 the bit is fixed, expected 0 if `par_even`=1 and 1 if `par_even`=0. A mismatch tags the character with a parity error.
- R4: A stop bit sampled low tags the character with a framing error. The receiver then returns to idle and looks for the next start bit.
- R5: If start, data, parity and stop bits are all sampled low, one character is stored with data 0 and both the break and framing tags set, and no parity tag. No further character is taken until the line has gone high.
- R6: If a character completes while the buffer holds 16 entries and no pop happens in that cycle, the character is dropped and `err_overrun` is set.
- R7: The buffer keeps up to 16 characters in arrival order. `data_ready` is high while it is non-empty. `rx_char` shows the oldest character, and a `pop` pulse removes it. After reset the buffer is empty and all flags are 0.
- R8: `trig_hit` is high while the fill count is at least the threshold selected by `trig_sel`: 00 means 1, 01 means 4, 10 means 8 and 11 means 14.
- R9: `fifo_err` is high while at least one stored character carries a parity, framing or break tag.
- R10: A `flush` pulse empties the buffer. `data_ready`, `trig_hit` and `fifo_err` are low the cycle after it.
- R11: `err_parity`, `err_frame` and `err_break` take on the tags of a character in the cycle it becomes the oldest entry. These flags and `err_overrun` clear on a `stat_rd` pulse. A tag arriving in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversampling enable |
| rx_line | input | 1 | Serial input, idle high |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select / stick value select |
| par_stick | input | 1 | Fixed parity bit |
| trig_sel | input | 2 | Threshold code: 1/4/8/14 entries |
| flush | input | 1 | Empty the receive buffer |
| pop | input | 1 | Remove the oldest character |
| stat_rd | input | 1 | Status read; clears error flags |
| rx_char | output | 8 | Oldest stored character |
| data_ready | output | 1 | Buffer non-empty |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_break | output | 1 | Break flag |
| err_overrun | output | 1 | Overrun flag |
| fifo_err | output | 1 | Some stored character carries an error tag |
| trig_hit | output | 1 | Fill count at or above threshold |

## Verification
A wrong bit counter or a mis-centred sample shows up as a corrupted character or a false parity tag. It appears on `rx_char` as soon as that frame is popped, one frame time after the fault. A corrupted read or write pointer shows as characters out of order or repeated. A corrupted fill count shows as `trig_hit`, `data_ready` or `err_overrun` changing at the wrong character. A drifting error-tag count leaves `fifo_err` high after the buffer has been drained. A stale head flag shows as error flags that belong to a neighbouring character.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } rx_state_t;

    // threshold code to entry count
    function automatic int unsigned trig_depth(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_regs_t;

    sync_regs_t q, d;

    always_comb begin
        d = q;
        d.pipe = {q.pipe[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{pipe: '1};
        else        q <= d;
    end

    assign dout = q.pipe[STAGES-1];
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       push,
    output rx_entry_t  push_entry
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_t         state;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        bidx;
        logic [CHAR_W-1:0] shreg;
        logic              allz;
        logic              pe;
    } deser_regs_t;

    deser_regs_t q, d;
    logic [2:0] last_idx;
    logic       par_exp;

    always_comb begin
        d          = q;
        push       = 1'b0;
        push_entry = '0;
        last_idx   = 3'd4 + {1'b0, word_len};
        par_exp    = par_stick ? ~par_even : (par_even ? ^q.shreg : ~^q.shreg);

        unique case (q.state)
            ST_IDLE: begin
                if (tick && !rx_s) begin
                    d.state = ST_START;
                    d.cnt   = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == MID) begin
                        d.cnt = '0;
                        if (rx_s) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.state = ST_DATA;
                            d.bidx  = '0;
                            d.shreg = '0;
                            d.allz  = 1'b1;
                            d.pe    = 1'b0;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA, ST_PAR, ST_STOP: begin
                if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        if (q.state == ST_DATA) begin
                            d.shreg[q.bidx] = rx_s;
                            d.allz = q.allz & ~rx_s;
                            if (q.bidx == last_idx) d.state = par_en ? ST_PAR : ST_STOP;
                            else                    d.bidx  = q.bidx + 1'b1;
                        end else if (q.state == ST_PAR) begin
                            d.pe    = (rx_s != par_exp);
                            d.allz  = q.allz & ~rx_s;
                            d.state = ST_STOP;
                        end else begin
                            push = 1'b1;
                            if (q.allz && !rx_s) begin
                                push_entry = '{brk: 1'b1, frm: 1'b1, par: 1'b0, data: '0};
                                d.state    = ST_BRK;
                            end else begin
                                push_entry = '{brk: 1'b0, frm: ~rx_s, par: q.pe, data: q.shreg};
                                d.state    = ST_IDLE;
                            end
                        end
                    end
                end
            end
            ST_BRK: begin
                if (rx_s) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, cnt: '0, bidx: '0, shreg: '0, allz: 1'b0, pe: 1'b0};
        else        q <= d;
    end

    // R1: high line at the start-bit centre abandons the character
    p_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START && tick && q.cnt == MID && rx_s) |=> (q.state == ST_IDLE && !push));

    // R5: break entries carry framing and zero data
    p_break_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> (push_entry.frm && push_entry.data == '0 && !push_entry.par));

    // R5: no new reception while the line stays low after a break
    p_break_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BRK && !rx_s) |=> (q.state == ST_BRK && !push));
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  rx_entry_t         push_entry,
    input  logic              pop,
    input  logic              stat_rd,
    input  logic              flush,
    input  logic [1:0]        trig_sel,
    output logic [CHAR_W-1:0] head_data,
    output logic              ready,
    output logic              flg_pe,
    output logic              flg_fe,
    output logic              flg_bi,
    output logic              flg_oe,
    output logic              any_err,
    output logic              trig_hit
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]    PTR_MAX = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wptr;
        logic [AW-1:0]         rptr;
        logic [CNT_W-1:0]      count;
        logic [CNT_W-1:0]      errcnt;
        logic                  pe;
        logic                  fe;
        logic                  bi;
        logic                  oe;
    } buf_regs_t;

    buf_regs_t q, d;
    logic      empty, full, do_pop, do_push, arrive, push_bad, head_bad;
    logic [AW-1:0] rptr_nx, wptr_nx;
    rx_entry_t head, arr_e;

    always_comb begin
        d        = q;
        empty    = (q.count == '0);
        full     = (q.count == FULL);
        head     = q.mem[q.rptr];
        do_pop   = pop && !empty;
        do_push  = push && (!full || do_pop);
        rptr_nx  = (q.rptr == PTR_MAX) ? '0 : q.rptr + 1'b1;
        wptr_nx  = (q.wptr == PTR_MAX) ? '0 : q.wptr + 1'b1;
        push_bad = push_entry.brk | push_entry.frm | push_entry.par;
        head_bad = head.brk | head.frm | head.par;

        if (do_push) begin
            d.mem[q.wptr] = push_entry;
            d.wptr        = wptr_nx;
        end
        if (do_pop) d.rptr = rptr_nx;
        d.count  = q.count + CNT_W'(do_push) - CNT_W'(do_pop);
        d.errcnt = q.errcnt + CNT_W'(do_push && push_bad) - CNT_W'(do_pop && head_bad);

        // which entry becomes the oldest in this cycle
        arrive = 1'b0;
        arr_e  = '0;
        if (do_pop) begin
            if (q.count > CNT_W'(1)) begin
                arrive = 1'b1;
                arr_e  = q.mem[rptr_nx];
            end else if (do_push) begin
                arrive = 1'b1;
                arr_e  = push_entry;
            end
        end else if (empty && do_push) begin
            arrive = 1'b1;
            arr_e  = push_entry;
        end

        if (stat_rd) begin
            d.pe = 1'b0;
            d.fe = 1'b0;
            d.bi = 1'b0;
            d.oe = 1'b0;
        end
        if (arrive) begin
            d.pe = d.pe | arr_e.par;
            d.fe = d.fe | arr_e.frm;
            d.bi = d.bi | arr_e.brk;
        end
        if (push && full && !do_pop) d.oe = 1'b1;

        if (flush) begin
            d.wptr   = '0;
            d.rptr   = '0;
            d.count  = '0;
            d.errcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready     = (q.count != '0);
    assign head_data = ready ? q.mem[q.rptr].data : '0;
    assign flg_pe    = q.pe;
    assign flg_fe    = q.fe;
    assign flg_bi    = q.bi;
    assign flg_oe    = q.oe;
    assign any_err   = (q.errcnt != '0);
    assign trig_hit  = (q.count >= CNT_W'(trig_depth(trig_sel)));

    // R7: fill count never exceeds the depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= FULL);

    // R6: completion into a full buffer without pop raises overrun, count stays full
    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (q.oe && q.count == FULL));

    // R9: tagged-entry count stays within the fill count
    p_errsum_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.errcnt <= q.count);

    // R10: flush empties the buffer
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q.count == '0 && q.errcnt == '0));

    // R11: a status read with no head change leaves every flag clear
    p_stat_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !push && !pop) |=> (!q.pe && !q.fe && !q.bi && !q.oe));
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_line,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic [1:0]        trig_sel,
    input  logic              flush,
    input  logic              pop,
    input  logic              stat_rd,
    output logic [CHAR_W-1:0] rx_char,
    output logic              data_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_overrun,
    output logic              fifo_err,
    output logic              trig_hit
);
    logic      rx_s;
    logic      push;
    rx_entry_t push_entry;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    serial_rx_deser #(.OSR(OSR)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_s      (rx_s),
        .word_len  (word_len),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .push      (push),
        .push_entry(push_entry)
    );

    serial_rx_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_entry(push_entry),
        .pop       (pop),
        .stat_rd   (stat_rd),
        .flush     (flush),
        .trig_sel  (trig_sel),
        .head_data (rx_char),
        .ready     (data_ready),
        .flg_pe    (err_parity),
        .flg_fe    (err_frame),
        .flg_bi    (err_break),
        .flg_oe    (err_overrun),
        .any_err   (fifo_err),
        .trig_hit  (trig_hit)
    );
endmodule

// File: tb/tb_serial_rx_top.sv
module tb_serial_rx_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rx_line = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       flush = 1'b0, pop = 1'b0, stat_rd = 1'b0;
    logic [7:0] rx_char;
    logic       data_ready, err_parity, err_frame, err_break, err_overrun, fifo_err, trig_hit;

    serial_rx_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
        .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .trig_sel(trig_sel), .flush(flush), .pop(pop), .stat_rd(stat_rd),
        .rx_char(rx_char), .data_ready(data_ready), .err_parity(err_parity),
        .err_frame(err_frame), .err_break(err_break), .err_overrun(err_overrun),
        .fifo_err(fifo_err), .trig_hit(trig_hit)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [7:0] d;
        bit pe;
        bit fe;
        bit bi;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   mon_en = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare the head against the scoreboard, then pop and read status
    task automatic read_check(input string tag);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk({tag, " R7 unexpected character"}, 1, 0);
        end else begin
            e = exp_q.pop_front();
            chk({tag, " R7/R2 data"}, int'(rx_char), int'(e.d));
            chk({tag, " R3/R11 parity flag"}, int'(err_parity), int'(e.pe));
            chk({tag, " R4/R11 frame flag"}, int'(err_frame), int'(e.fe));
            chk({tag, " R5/R11 break flag"}, int'(err_break), int'(e.bi));
        end
        pop = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        stat_rd = 1'b0;
    endtask

    task automatic bit_time();
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_hi, input bit track);
        int         nb;
        logic [7:0] m;
        logic       pb;
        exp_t       e;
        nb = 5 + int'(word_len);
        m  = d & ((8'h1 << nb) - 8'h1);
        pb = par_stick ? ~par_even : (par_even ? ^m : ~^m);
        if (track) begin
            e.d = m; e.pe = bad_par; e.fe = !stop_hi; e.bi = 1'b0;
            exp_q.push_back(e);
        end
        rx_line = 1'b0; bit_time();
        for (int i = 0; i < nb; i++) begin
            rx_line = m[i]; bit_time();
        end
        if (par_en) begin
            rx_line = pb ^ bad_par; bit_time();
        end
        rx_line = stop_hi; bit_time();
        rx_line = 1'b1; bit_time();
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (mon_en && data_ready) read_check("mon");
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin : main
        exp_t eb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7 reset state
        chk("R7 reset data_ready", int'(data_ready), 0);
        chk("R11 reset flags", int'({err_parity, err_frame, err_break, err_overrun}), 0);
        chk("R9 reset fifo_err", int'(fifo_err), 0);
        chk("R8 reset trig_hit", int'(trig_hit), 0);

        mon_en = 1'b1;
        // R2 8 bits no parity, several patterns
        send_frame(8'hA5, 0, 1, 1);
        send_frame(8'h3C, 0, 1, 1);
        send_frame(8'h01, 0, 1, 1);
        // R2 5 bits
        word_len = 2'b00;
        send_frame(8'hFF, 0, 1, 1);
        send_frame(8'h0A, 0, 1, 1);
        // R3 7 bits even, odd, stick
        word_len = 2'b10; par_en = 1'b1; par_even = 1'b1;
        send_frame(8'h55, 0, 1, 1);
        send_frame(8'h07, 1, 1, 1);
        par_even = 1'b0;
        send_frame(8'h12, 0, 1, 1);
        send_frame(8'h13, 1, 1, 1);
        par_stick = 1'b1; par_even = 1'b1;
        send_frame(8'h7F, 0, 1, 1);
        par_even = 1'b0;
        send_frame(8'h40, 0, 1, 1);
        send_frame(8'h41, 1, 1, 1);
        par_stick = 1'b0; par_en = 1'b0; word_len = 2'b11;
        // R4 framing error then recovery
        send_frame(8'h81, 0, 0, 1);
        send_frame(8'h42, 0, 1, 1);
        repeat (40) @(negedge clk);
        chk("R4 all characters seen", exp_q.size(), 0);

        // R1 false start: short low glitch
        rx_line = 1'b0;
        repeat (5) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R1 false start stores nothing", int'(data_ready), 0);
        send_frame(8'hC3, 0, 1, 1);
        repeat (40) @(negedge clk);
        chk("R1 recovery after false start", exp_q.size(), 0);

        // R5 break: 8 bits + parity, line low for 14 bit times
        par_en = 1'b1; par_even = 1'b1;
        eb.d = 8'h00; eb.pe = 1'b0; eb.fe = 1'b1; eb.bi = 1'b1;
        exp_q.push_back(eb);
        rx_line = 1'b0;
        repeat (14) bit_time();
        rx_line = 1'b1;
        repeat (64) @(negedge clk);
        chk("R5 single break entry", exp_q.size(), 0);
        chk("R5 nothing after break", int'(data_ready), 0);
        par_en = 1'b0;

        // R8 thresholds and R6 overrun, manual draining
        mon_en = 1'b0;
        repeat (4) @(negedge clk);
        trig_sel = 2'b01;
        for (int i = 0; i < 3; i++) send_frame(8'h10 + 8'(i), 0, 1, 1);
        chk("R8 below 4", int'(trig_hit), 0);
        send_frame(8'h13, 0, 1, 1);
        chk("R8 reached 4", int'(trig_hit), 1);
        for (int i = 4; i < 8; i++) send_frame(8'h10 + 8'(i), 0, 1, 1);
        trig_sel = 2'b10;
        @(negedge clk);
        chk("R8 reached 8", int'(trig_hit), 1);
        trig_sel = 2'b11;
        @(negedge clk);
        chk("R8 below 14", int'(trig_hit), 0);
        for (int i = 8; i < 14; i++) send_frame(8'h10 + 8'(i), 0, 1, 1);
        chk("R8 reached 14", int'(trig_hit), 1);
        send_frame(8'h1E, 0, 1, 1);
        send_frame(8'h1F, 0, 1, 1);
        chk("R6 no overrun at 16", int'(err_overrun), 0);
        send_frame(8'hEE, 0, 1, 0);
        chk("R6 overrun flagged", int'(err_overrun), 1);
        read_check("drain");
        chk("R11 overrun cleared by status read", int'(err_overrun), 0);
        for (int i = 1; i < 16; i++) read_check("drain");
        chk("R6 dropped character not stored", int'(data_ready), 0);

        // R9 summary and R11 head reporting
        trig_sel = 2'b00;
        send_frame(8'h11, 0, 1, 1);
        par_en = 1'b1;
        send_frame(8'h22, 1, 1, 1);
        par_en = 1'b0;
        chk("R9 summary with tagged entry", int'(fifo_err), 1);
        chk("R11 tag not shown before head", int'(err_parity), 0);
        read_check("err");
        chk("R9 summary while tagged entry stays", int'(fifo_err), 1);
        read_check("err");
        chk("R9 summary clears when drained", int'(fifo_err), 0);

        // R10 flush
        send_frame(8'h5A, 0, 1, 0);
        par_en = 1'b1;
        send_frame(8'h5B, 1, 1, 0);
        par_en = 1'b0;
        chk("R10 filled before flush", int'(data_ready), 1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R10 data_ready after flush", int'(data_ready), 0);
        chk("R10 trig_hit after flush", int'(trig_hit), 0);
        chk("R10 fifo_err after flush", int'(fifo_err), 0);

        finish_run();
    end
endmodule